// File: doc/BRIEF.md
# Transmit-Disable Bias and Modulation Controller

This block owns the laser bias code and the modulation code of an optical transmitter, and handles what happens to them when transmission is turned off and on. Transmission is turned off by a hardware disable pin, by a software disable bit, or by both. The effective disable is the OR of the two, and the two controls have the same effect. While disabled, both codes and the ready flag are forced to zero. The pin passes through a two-flop synchroniser first. The software bit is a register field in the same clock domain and acts in the same cycle.

When the disable clears, the block takes the modulation code from a temperature-indexed value presented at its input. It then rebuilds the bias code from scratch with the same successive-approximation search that follows reset. It does not resume the old bias value.

The search tests one bias bit per accepted comparator result. Results arrive on a valid/ready handshake. `cmp_ready` is high only while a search step is waiting, and a result is consumed on any edge where `cmp_valid` and `cmp_ready` are both high. The block never stalls the comparator in any other way. The source may hold `cmp_valid` low for as long as it likes, and the search simply waits. Once the last bit is settled, `ready` rises and both codes stay frozen for the closed-loop controller that takes over.

Top module: `txd_bias_mod_ctrl`

## Requirements
- R1: The effective disable is `txd_pin` (after synchronisation) OR `txd_soft`. While `txd_soft` is 1, `bias_code`, `mod_code`, `ready` and `cmp_ready` are 0 in that same cycle.
- R2: `txd_pin` goes through two flip-flops. Once the pin has been 1 at two rising edges in a row, the outputs are zero, so the turn-off bound is two clocks.
- R3: While disabled, the outputs stay zero whatever the comparator and the modulation input do.
- R4: On the second rising edge after the effective disable falls, `mod_code` takes the value of `mod_temp`. Changes on `mod_temp` after that edge are ignored until the next release.
- R5: On that same edge, `bias_code` becomes the first trial, which has only the MSB set (0x80 for 8 bits), and `cmp_ready` rises.
- R6: Each accepted result keeps the bit under test if `cmp_below`=1 and clears it if `cmp_below`=0. It then sets the next lower bit as the new trial. An edge with `cmp_valid`=0 leaves the trial unchanged.
- R7: After the LSB has been decided, `ready`=1 and `cmp_ready`=0. If the comparator reports below exactly when `bias_code` < T, the final code is T-1, or 0 when T=0.
- R8: While `ready`=1, `bias_code` and `mod_code` do not change, whatever the comparator inputs do.
- R9: Disable asserted in the middle of a search abandons it and zeroes the outputs. The next release starts again from the MSB trial.
- R10: Reset leaves the block in the disabled state. When reset is released with no disable active, the startup search follows the same timing as a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_pin | input | 1 | Hardware transmit disable, asynchronous, 1 = off |
| txd_soft | input | 1 | Software transmit disable, synchronous, 1 = off |
| mod_temp | input | 8 | Modulation code for the present temperature |
| cmp_valid | input | 1 | Comparator result valid |
| cmp_below | input | 1 | 1 = measured power is below the set point |
| cmp_ready | output | 1 | Search is waiting for a comparator result |
| bias_code | output | 8 | Bias code: the trial value during the search, the result afterwards |
| mod_code | output | 8 | Modulation code |
| ready | output | 1 | Search finished; codes handed to loop control |

## Verification
The hardest state to reach from the ports is a disable that lands in the middle of a search, with the comparator still offering results, followed by a clean restart. The bench drives a comparator model that answers from the present `bias_code` against a threshold. It counts edges after a release so that the soft bit rises partway through the bit tests, keeps the comparator active while disabled, and then checks that the MSB trial reappears. The final code is swept over every threshold from 0 to 256, including runs with stalled `cmp_valid` cycles, so each step of the search is checked against the arithmetic result.

// File: rtl/txd_ctrl_pkg.sv
package txd_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_LOAD   = 2'd1,
    ST_SEARCH = 2'd2,
    ST_RUN    = 2'd3
  } txd_state_e;
endpackage

// File: rtl/txd_sync.sv
module txd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic off,
  input  logic done,
  output logic load,
  output logic search,
  output logic run
);
  txd_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    if (off) begin
      state_n = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:    state_n = ST_LOAD;
        ST_LOAD:   state_n = ST_SEARCH;
        ST_SEARCH: state_n = done ? ST_RUN : ST_SEARCH;
        ST_RUN:    state_n = ST_RUN;
        default:   state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_n;
  end

  assign load   = !off && (state_q == ST_LOAD);
  assign search = !off && (state_q == ST_SEARCH);
  assign run    = !off && (state_q == ST_RUN);
endmodule

// File: rtl/txd_sar.sv
module txd_sar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         start,
  input  logic         step,
  input  logic         keep,
  output logic [W-1:0] code,
  output logic         done
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (clr) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      code_q <= TOP_BIT;
      mask_q <= TOP_BIT;
    end else if (step) begin
      code_q <= (keep ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end

  assign code = code_q;
  assign done = step && mask_q[0];
endmodule

// File: rtl/txd_mod_hold.sv
module txd_mod_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (clr)  q_r <= '0;
    else if (load) q_r <= din;
  end

  assign q = q_r;
endmodule

// File: rtl/txd_bias_mod_ctrl.sv
module txd_bias_mod_ctrl #(
  parameter int BIAS_W      = 8,
  parameter int MOD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txd_pin,
  input  logic              txd_soft,
  input  logic [MOD_W-1:0]  mod_temp,
  input  logic              cmp_valid,
  input  logic              cmp_below,
  output logic              cmp_ready,
  output logic [BIAS_W-1:0] bias_code,
  output logic [MOD_W-1:0]  mod_code,
  output logic              ready
);
  logic pin_s, off;
  logic load, search, run, done, step;
  logic [BIAS_W-1:0] sar_code;
  logic [MOD_W-1:0]  mod_q;

  txd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(txd_pin), .q(pin_s)
  );

  assign off  = pin_s | txd_soft;
  assign step = cmp_valid && search;

  txd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .off(off), .done(done),
    .load(load), .search(search), .run(run)
  );

  txd_sar #(.W(BIAS_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr(off), .start(load),
    .step(step), .keep(cmp_below), .code(sar_code), .done(done)
  );

  txd_mod_hold #(.W(MOD_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .clr(off), .load(load),
    .din(mod_temp), .q(mod_q)
  );

  assign cmp_ready = search;
  assign ready     = run;
  assign bias_code = off ? '0 : sar_code;
  assign mod_code  = off ? '0 : mod_q;
endmodule

// File: rtl/txd_ctrl_chk.sv
module txd_ctrl_chk #(
  parameter int BIAS_W = 8,
  parameter int MOD_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd_pin,
  input logic              txd_soft,
  input logic              cmp_ready,
  input logic [BIAS_W-1:0] bias_code,
  input logic [MOD_W-1:0]  mod_code,
  input logic              ready
);
  localparam logic [BIAS_W-1:0] FIRST_TRIAL = {1'b1, {(BIAS_W-1){1'b0}}};

  // R1
  soft_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txd_soft |-> (bias_code == '0 && mod_code == '0 && !ready && !cmp_ready));

  // R2
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txd_pin ##1 txd_pin |=> (bias_code == '0 && mod_code == '0 && !ready));

  // R5
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_ready) |-> bias_code == FIRST_TRIAL);

  // R7
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && cmp_ready));

  // R8
  bias_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(bias_code));

  // R4
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ready && $past(ready)) || (cmp_ready && $past(cmp_ready))) |-> $stable(mod_code));
endmodule

bind txd_bias_mod_ctrl txd_ctrl_chk #(.BIAS_W(BIAS_W), .MOD_W(MOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd_pin(txd_pin), .txd_soft(txd_soft),
  .cmp_ready(cmp_ready), .bias_code(bias_code), .mod_code(mod_code), .ready(ready)
);

// File: tb/test_txd_bias_mod_ctrl.sv
module test_txd_bias_mod_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txd_pin = 1'b0;
  logic       txd_soft = 1'b1;
  logic [7:0] mod_temp = 8'd0;
  logic       cmp_valid = 1'b0;
  logic       cmp_below = 1'b0;
  logic       cmp_ready;
  logic [7:0] bias_code;
  logic [7:0] mod_code;
  logic       ready;

  int total = 0;
  int fails = 0;
  int thr = 0;
  int cyc = 0;
  bit resp_en = 1'b0;
  bit gap = 1'b0;

  always #2 clk = ~clk;

  txd_bias_mod_ctrl i_txd_bias_mod_ctrl (
    .clk(clk), .rst_n(rst_n), .txd_pin(txd_pin), .txd_soft(txd_soft),
    .mod_temp(mod_temp), .cmp_valid(cmp_valid), .cmp_below(cmp_below),
    .cmp_ready(cmp_ready), .bias_code(bias_code), .mod_code(mod_code), .ready(ready)
  );

  // comparator model: power below set point when bias < thr
  always @(negedge clk) begin
    cyc = cyc + 1;
    cmp_below = (int'(bias_code) < thr);
    cmp_valid = resp_en && !(gap && (cyc % 3 == 0));
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ready(input string req);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      if (ready) break;
    end
    chk(req, int'(ready), 1);
  endtask

  function automatic int sar_result(input int t);
    return (t == 0) ? 0 : t - 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int held;
    // R10 reset state while soft disable is held
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 reset bias", int'(bias_code), 0);
    chk("R10 reset mod", int'(mod_code), 0);
    chk("R10 reset ready", int'(ready), 0);

    // R10 startup search with no disable
    @(negedge clk);
    rst_n = 1'b0;
    txd_soft = 1'b0;
    thr = 100;
    mod_temp = 8'd42;
    resp_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R10 startup first trial", int'(bias_code), 128);
    chk("R10 startup mod", int'(mod_code), 42);
    wait_ready("R10 startup ready");
    chk("R10 startup result", int'(bias_code), 99);

    // R1 R4 R5 R7 R8: sweep every threshold via soft disable
    for (int t = 0; t <= 256; t++) begin
      int mv;
      @(negedge clk);
      txd_soft = 1'b1;
      #1;
      chk("R1 soft zeroes bias", int'(bias_code), 0);
      chk("R1 soft zeroes mod", int'(mod_code), 0);
      chk("R1 soft clears ready", int'(ready), 0);
      @(negedge clk);
      thr = t;
      gap = (t % 2 == 1);
      mv = (t * 37 + 5) & 255;
      mod_temp = mv[7:0];
      txd_soft = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1;
      chk("R5 first trial", int'(bias_code), 128);
      chk("R5 cmp_ready", int'(cmp_ready), 1);
      chk("R4 mod loaded", int'(mod_code), mv);
      mod_temp = ~mv[7:0];
      wait_ready("R7 ready");
      chk("R7 result", int'(bias_code), sar_result(t));
      chk("R7 cmp_ready low", int'(cmp_ready), 0);
      chk("R4 mod ignores later input", int'(mod_code), mv);
      // R8: comparator keeps toggling while ready
      thr = 255 - (t % 256);
      repeat (4) @(negedge clk);
      #1;
      chk("R8 bias held", int'(bias_code), sar_result(t));
      chk("R8 mod held", int'(mod_code), mv);
    end
    gap = 1'b0;

    // R6 stalled valid then single decision
    @(negedge clk);
    txd_soft = 1'b1;
    resp_en = 1'b0;
    thr = 50;
    @(negedge clk);
    txd_soft = 1'b0;
    @(posedge clk);
    @(posedge clk);
    repeat (5) @(negedge clk);
    #1;
    chk("R6 stall keeps trial", int'(bias_code), 128);
    chk("R6 stall cmp_ready", int'(cmp_ready), 1);
    @(posedge clk);
    #1;
    resp_en = 1'b1;
    @(posedge clk);
    #1;
    chk("R6 clear bit and next trial", int'(bias_code), 64);
    @(posedge clk);
    #1;
    chk("R6 clear again", int'(bias_code), 32);
    @(posedge clk);
    #1;
    chk("R6 keep bit", int'(bias_code), 48);
    wait_ready("R6 ready");
    chk("R6 result", int'(bias_code), 49);

    // R9 abort mid search, R3 stays zero, restart from MSB
    @(negedge clk);
    txd_soft = 1'b1;
    thr = 200;
    mod_temp = 8'd77;
    @(negedge clk);
    txd_soft = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk("R9 still searching", int'(cmp_ready), 1);
    @(negedge clk);
    txd_soft = 1'b1;
    #1;
    chk("R9 abort bias", int'(bias_code), 0);
    chk("R9 abort ready", int'(ready), 0);
    held = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      mod_temp = 8'(k * 13);
      if (bias_code != 0 || mod_code != 0 || cmp_ready) held++;
    end
    chk("R3 outputs stay zero", held, 0);
    mod_temp = 8'd91;
    txd_soft = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R9 restart trial", int'(bias_code), 128);
    chk("R9 restart mod", int'(mod_code), 91);
    wait_ready("R9 ready");
    chk("R9 result", int'(bias_code), 199);

    // R2 pin turn-off within two clocks, release and re-search
    @(negedge clk);
    txd_pin = 1'b1;
    @(posedge clk);
    #1;
    chk("R2 one clock not yet off", int'(ready), 1);
    @(posedge clk);
    #1;
    chk("R2 bias off in two clocks", int'(bias_code), 0);
    chk("R2 mod off in two clocks", int'(mod_code), 0);
    chk("R2 ready off", int'(ready), 0);
    @(negedge clk);
    thr = 17;
    mod_temp = 8'd200;
    txd_pin = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 pin release first trial", int'(bias_code), 128);
    chk("R1 pin release mod", int'(mod_code), 200);
    wait_ready("R1 pin ready");
    chk("R1 pin result", int'(bias_code), 16);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule